// File: doc/BRIEF.md
# Address Monitor Wake Unit

This unit lets a core sleep until a chosen memory line is written by another agent. Software first arms the unit with the virtual address to watch. A later wait command starts a probing read of that address, sized to stay inside one cache line. When the translated physical address of that read comes back, the unit keeps its line-aligned form and raises a halt request to the core. The exception is a wake that already arrived since the last wait: that wake is consumed and the core is not halted.

While the core sleeps, every coherence snoop address is compared, at line granularity, with the kept line. A hit ends the sleep, drops the halt request and gives a one-cycle wake pulse. Any wake seen by the unit, from a snoop hit or from an external wake input, leaves a sticky flag behind. That flag stops the next wait from sleeping through an event it has already missed. Address translation, the cache and the coherence fabric sit outside the unit and reach it only through plain valid/address ports.

Top module: `mon_wake_unit`

## Requirements
- R1: After a synchronous active-low reset, halt_o, wake_o, rd_req_o and wait_done_o are low, and the unit is neither armed, waiting nor holding a pending wake.
- R2: An arm command (arm_valid_i) stores arm_vaddr_i as the watched address. Every later probing read carries that address until the next arm.
- R3: An accepted wait_go_i gives a single-cycle rd_req_o on the next cycle. rd_addr_o carries the watched address. rd_size_o carries 8 bytes, or the bytes left up to the end of the line if fewer (line size LINE_BYTES, default 64).
- R4: While a probing read is outstanding, wait_go_i is ignored. A rsp_valid_i with no read outstanding is ignored and gives no wait_done_o.
- R5: A read response with no pending wake stores rsp_paddr_i with its low log2(LINE_BYTES) bits cleared as the watched line. From the next cycle, halt_o is high and wait_done_o pulses for one cycle.
- R6: A read response while a wake is pending clears the pending flag. halt_o stays low and wait_done_o pulses for one cycle.
- R7: A snoop whose line-aligned address equals the watched line, while armed and waiting, gives halt_o low and a one-cycle wake_o on the next cycle.
- R8: A snoop that misses, or that arrives while not armed or not waiting, leaves halt_o, wake_o and all state unchanged.
- R9: Both a snoop hit and ext_wake_i set the pending-wake flag, so the next read response does not halt.
- R10: An arm while waiting drops halt_o without a wake pulse, replaces the watched address and clears the watched line to zero. A snoop of the old line then has no effect.
- R11: A read response and a snoop in the same cycle are ordered response first. A snoop hitting the new line wakes at once: wake_o pulses and halt_o never rises.
- R12: An arm in the same cycle as a read response wins. The response is dropped with no wait_done_o, and no read stays outstanding. A wait_go_i in the same cycle as an arm reads the newly armed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_valid_i | input | 1 | Arm command strobe |
| arm_vaddr_i | input | ADDR_W | Virtual address to watch |
| wait_go_i | input | 1 | Wait command strobe, starts the probing read |
| rd_req_o | output | 1 | Probing read request pulse |
| rd_addr_o | output | ADDR_W | Address of the probing read |
| rd_size_o | output | SZ_W | Byte count of the probing read |
| rsp_valid_i | input | 1 | Probing read completed |
| rsp_paddr_i | input | ADDR_W | Translated physical address of the read |
| snoop_valid_i | input | 1 | Coherence snoop strobe |
| snoop_addr_i | input | ADDR_W | Snoop physical address |
| ext_wake_i | input | 1 | Wake event from another source |
| wake_o | output | 1 | One-cycle wake pulse on a snoop hit |
| halt_o | output | 1 | Halt request, high while waiting |
| wait_done_o | output | 1 | One-cycle pulse when a wait response is consumed |

## Verification
The assertions rely on one assumption: a read response matters only when a read is outstanding. They tie wait_done_o, a rising halt_o and rd_req_o to the strobe seen one cycle earlier, and they take no view on what the environment sends between those events. The stimulus is free to send stray responses, repeated wait commands and snoops at any time. Only the arm rate is kept low, so that sleeps last long enough to be hit. Snoop addresses are drawn mostly from the watched line with a random byte offset, so hits, near misses and same-cycle collisions all occur often.

// File: rtl/mwu_pkg.sv
// Package: shared defaults for the address monitor wake unit.
// Assumes: line size is a power of two of at least 2 bytes.
package mwu_pkg;
    localparam int DEF_ADDR_W     = 64;
    localparam int DEF_LINE_BYTES = 64;
    localparam int DEF_RD_BYTES   = 8;

    // outcome of a read response, used for readable control decoding
    typedef enum logic [1:0] {
        RSP_NONE    = 2'd0,
        RSP_CAPTURE = 2'd1,
        RSP_CONSUME = 2'd2
    } rsp_kind_e;
endpackage

// File: rtl/mwu_align.sv
// Module: clears the byte-offset bits of an address to give its line address.
// Assumes: LINE_BYTES is a power of two and not larger than 2**ADDR_W.
module mwu_align #(
    parameter int ADDR_W     = mwu_pkg::DEF_ADDR_W,
    parameter int LINE_BYTES = mwu_pkg::DEF_LINE_BYTES
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] line_o
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

    // mask away the offset inside the line
    always_comb begin
        line_o = addr_i & ~OFF_MASK;
    end
endmodule

// File: rtl/mwu_span.sv
// Module: computes the probing read size, cut so it ends at the line boundary.
// Assumes: LINE_BYTES is a power of two of at least 2; RD_BYTES at least 1.
module mwu_span #(
    parameter int LINE_BYTES = mwu_pkg::DEF_LINE_BYTES,
    parameter int RD_BYTES   = mwu_pkg::DEF_RD_BYTES,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int SZ_W      = $clog2(RD_BYTES) + 1
) (
    input  logic [OFF_W-1:0] off_i,
    output logic [SZ_W-1:0]  size_o
);
    logic [OFF_W:0] remain;

    // bytes left from the offset to the end of the line
    always_comb begin
        remain = (OFF_W+1)'(LINE_BYTES) - {1'b0, off_i};
    end

    generate
        if (LINE_BYTES > RD_BYTES) begin : g_clip
            // the line can hold a full read, so clip only near its end
            always_comb begin
                if (remain >= (OFF_W+1)'(RD_BYTES))
                    size_o = SZ_W'(RD_BYTES);
                else
                    size_o = SZ_W'(remain);
            end
        end else begin : g_short
            // the whole line is no larger than one read
            always_comb begin
                size_o = SZ_W'(remain);
            end
        end
    endgenerate
endmodule

// File: rtl/mwu_snoop_cmp.sv
// Module: line-granular comparison of a snoop address with the watched line.
// Assumes: line_i is already line aligned.
module mwu_snoop_cmp #(
    parameter int ADDR_W     = mwu_pkg::DEF_ADDR_W,
    parameter int LINE_BYTES = mwu_pkg::DEF_LINE_BYTES
) (
    input  logic [ADDR_W-1:0] snoop_addr_i,
    input  logic [ADDR_W-1:0] line_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] snoop_line;

    mwu_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
        .addr_i (snoop_addr_i),
        .line_o (snoop_line)
    );

    // equality at line granularity
    always_comb begin
        hit_o = (snoop_line == line_i);
    end
endmodule

// File: rtl/mwu_ctrl.sv
// Module: state of the monitor (armed, waiting, pending wake, read outstanding),
// the watched addresses and all registered outputs.
// Assumes: rsp_line_i is the aligned response address; snoop_hit_i compares
// the snoop against eff_line_o of the same cycle. Ordering inside a cycle:
// arm overrides a response, a response is applied before a snoop.
module mwu_ctrl
    import mwu_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int RD_BYTES   = DEF_RD_BYTES,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int SZ_W      = $clog2(RD_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_valid_i,
    input  logic [ADDR_W-1:0] arm_vaddr_i,
    input  logic              wait_go_i,
    input  logic              rsp_valid_i,
    input  logic [ADDR_W-1:0] rsp_line_i,
    input  logic              snoop_valid_i,
    input  logic              snoop_hit_i,
    input  logic              ext_wake_i,
    input  logic [SZ_W-1:0]   span_size_i,
    output logic [ADDR_W-1:0] eff_line_o,
    output logic [OFF_W-1:0]  sel_off_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [SZ_W-1:0]   rd_size_o,
    output logic              wake_o,
    output logic              halt_o,
    output logic              wait_done_o
);
    logic              armed_q, waiting_q, pend_q, busy_q;
    logic [ADDR_W-1:0] vaddr_q, line_q;
    logic              rd_req_q, wake_q, done_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic [SZ_W-1:0]   rd_size_q;

    rsp_kind_e         rsp_kind;
    logic              go_ok, wait_eff, match;
    logic [ADDR_W-1:0] addr_sel;

    // classify the response: dropped, captured into a sleep, or consuming a wake
    always_comb begin
        rsp_kind = RSP_NONE;
        if (rsp_valid_i && busy_q && !arm_valid_i)
            rsp_kind = pend_q ? RSP_CONSUME : RSP_CAPTURE;
    end

    // accept a wait command when no read is outstanding or an arm frees the slot
    always_comb begin
        go_ok    = wait_go_i && (!busy_q || arm_valid_i);
        addr_sel = arm_valid_i ? arm_vaddr_i : vaddr_q;
        sel_off_o = addr_sel[OFF_W-1:0];
    end

    // waiting state and line after the response step, before the snoop step
    always_comb begin
        wait_eff   = (rsp_kind == RSP_CAPTURE) ? 1'b1 : waiting_q;
        eff_line_o = (rsp_kind == RSP_CAPTURE) ? rsp_line_i : line_q;
        match      = snoop_valid_i && snoop_hit_i && armed_q && wait_eff && !arm_valid_i;
    end

    // monitor state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            waiting_q <= 1'b0;
            pend_q    <= 1'b0;
            busy_q    <= 1'b0;
            vaddr_q   <= '0;
            line_q    <= '0;
        end else begin
            if (arm_valid_i) begin
                armed_q   <= 1'b1;
                vaddr_q   <= arm_vaddr_i;
                line_q    <= '0;
                waiting_q <= 1'b0;
            end else begin
                line_q    <= eff_line_o;
                waiting_q <= wait_eff && !match;
            end
            pend_q <= (pend_q && (rsp_kind != RSP_CONSUME)) || match || ext_wake_i;
            if (go_ok)
                busy_q <= 1'b1;
            else if (arm_valid_i || rsp_kind != RSP_NONE)
                busy_q <= 1'b0;
        end
    end

    // registered output pulses and read request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req_q  <= 1'b0;
            rd_addr_q <= '0;
            rd_size_q <= '0;
            wake_q    <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            rd_req_q <= go_ok;
            if (go_ok) begin
                rd_addr_q <= addr_sel;
                rd_size_q <= span_size_i;
            end
            wake_q <= match;
            done_q <= (rsp_kind != RSP_NONE);
        end
    end

    always_comb begin
        rd_req_o    = rd_req_q;
        rd_addr_o   = rd_addr_q;
        rd_size_o   = rd_size_q;
        wake_o      = wake_q;
        halt_o      = waiting_q;
        wait_done_o = done_q;
    end

    // a read request follows a wait command of the previous cycle
    assert_rd_from_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_q |-> $past(wait_go_i));
    // a read request carries a size between one byte and a full read
    assert_rd_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_q |-> (rd_size_q != '0) && (rd_size_q <= SZ_W'(RD_BYTES)));
    // wait completion only after a response that no arm overrode
    assert_done_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(rsp_valid_i && !arm_valid_i));
    // the halt request only starts from a read response
    assert_halt_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(waiting_q) |-> $past(rsp_valid_i));
    // a wake pulse always leaves the core not halted
    assert_wake_clears_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> !waiting_q);
    // a wake pulse always leaves the pending flag set
    assert_wake_sets_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> pend_q);
    // an arm never produces a wake pulse
    assert_arm_no_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arm_valid_i |=> !wake_q);
endmodule

// File: rtl/mon_wake_unit.sv
// Module: top of the address monitor wake unit. Wires the aligner for read
// responses, the read-size calculator, the snoop comparator and the control.
// Assumes: LINE_BYTES is a power of two of at least 2 and at most 2**ADDR_W.
module mon_wake_unit #(
    parameter int ADDR_W     = mwu_pkg::DEF_ADDR_W,
    parameter int LINE_BYTES = mwu_pkg::DEF_LINE_BYTES,
    parameter int RD_BYTES   = mwu_pkg::DEF_RD_BYTES,
    localparam int SZ_W      = $clog2(RD_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_valid_i,
    input  logic [ADDR_W-1:0] arm_vaddr_i,
    input  logic              wait_go_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [SZ_W-1:0]   rd_size_o,
    input  logic              rsp_valid_i,
    input  logic [ADDR_W-1:0] rsp_paddr_i,
    input  logic              snoop_valid_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    input  logic              ext_wake_i,
    output logic              wake_o,
    output logic              halt_o,
    output logic              wait_done_o
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    logic [ADDR_W-1:0] rsp_line, eff_line;
    logic [OFF_W-1:0]  sel_off;
    logic [SZ_W-1:0]   span_size;
    logic              snoop_hit;

    mwu_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_rsp_align (
        .addr_i (rsp_paddr_i),
        .line_o (rsp_line)
    );

    mwu_span #(.LINE_BYTES(LINE_BYTES), .RD_BYTES(RD_BYTES)) u_span (
        .off_i  (sel_off),
        .size_o (span_size)
    );

    mwu_snoop_cmp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_cmp (
        .snoop_addr_i (snoop_addr_i),
        .line_i       (eff_line),
        .hit_o        (snoop_hit)
    );

    mwu_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .RD_BYTES(RD_BYTES)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_valid_i   (arm_valid_i),
        .arm_vaddr_i   (arm_vaddr_i),
        .wait_go_i     (wait_go_i),
        .rsp_valid_i   (rsp_valid_i),
        .rsp_line_i    (rsp_line),
        .snoop_valid_i (snoop_valid_i),
        .snoop_hit_i   (snoop_hit),
        .ext_wake_i    (ext_wake_i),
        .span_size_i   (span_size),
        .eff_line_o    (eff_line),
        .sel_off_o     (sel_off),
        .rd_req_o      (rd_req_o),
        .rd_addr_o     (rd_addr_o),
        .rd_size_o     (rd_size_o),
        .wake_o        (wake_o),
        .halt_o        (halt_o),
        .wait_done_o   (wait_done_o)
    );
endmodule

// File: tb/mon_wake_unit_tb.sv
// Bench: directed corner cases then seeded random traffic, checked every cycle
// against a cycle model built from the requirements.
module mon_wake_unit_tb;
    localparam int AW   = 64;
    localparam int LINE = 64;
    localparam int RD   = 8;
    localparam logic [63:0] MASK = ~64'(LINE - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm_v = 1'b0, go = 1'b0, rsp_v = 1'b0, snp_v = 1'b0, ext_w = 1'b0;
    logic [AW-1:0] arm_a = '0, rsp_a = '0, snp_a = '0;
    logic rd_req, wake, halt, done;
    logic [AW-1:0] rd_addr;
    logic [3:0] rd_size;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    bit finished = 1'b0;

    // model state
    logic m_armed = 0, m_wait = 0, m_pend = 0, m_busy = 0;
    logic [63:0] m_vaddr = '0, m_line = '0;
    logic e_rd_req = 0, e_wake = 0, e_done = 0;
    logic [63:0] e_rd_addr = '0;
    logic [3:0] e_rd_size = '0;

    always #4 clk = ~clk;

    mon_wake_unit #(.ADDR_W(AW), .LINE_BYTES(LINE), .RD_BYTES(RD)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .arm_valid_i(arm_v), .arm_vaddr_i(arm_a), .wait_go_i(go),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_size_o(rd_size),
        .rsp_valid_i(rsp_v), .rsp_paddr_i(rsp_a),
        .snoop_valid_i(snp_v), .snoop_addr_i(snp_a), .ext_wake_i(ext_w),
        .wake_o(wake), .halt_o(halt), .wait_done_o(done)
    );

    function automatic logic [3:0] exp_size(input logic [63:0] a);
        int rem;
        rem = LINE - int'(a % LINE);
        return (rem < RD) ? 4'(rem) : 4'(RD);
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    // advance the requirement model by one clock with the current inputs
    task automatic model_step();
        logic rsp_ok, go_ok, capture, consume, w1, match;
        logic [63:0] l1, sel;
        rsp_ok  = rsp_v && m_busy && !arm_v;
        go_ok   = go && (!m_busy || arm_v);
        sel     = arm_v ? arm_a : m_vaddr;
        capture = rsp_ok && !m_pend;
        consume = rsp_ok && m_pend;
        w1      = capture ? 1'b1 : m_wait;
        l1      = capture ? (rsp_a & MASK) : m_line;
        match   = snp_v && m_armed && w1 && !arm_v && ((snp_a & MASK) == l1);
        e_rd_req = go_ok;
        if (go_ok) begin
            e_rd_addr = sel;
            e_rd_size = exp_size(sel);
        end
        e_wake = match;
        e_done = rsp_ok;
        if (arm_v) begin
            m_armed = 1'b1;
            m_vaddr = arm_a;
            m_line  = '0;
            m_wait  = 1'b0;
        end else begin
            m_line = l1;
            m_wait = w1 && !match;
        end
        m_pend = (m_pend && !consume) || match || ext_w;
        if (go_ok) m_busy = 1'b1;
        else if (arm_v || rsp_ok) m_busy = 1'b0;
    endtask

    task automatic step(input logic a_v, input logic [63:0] a_a, input logic g,
                        input logic r_v, input logic [63:0] r_a,
                        input logic s_v, input logic [63:0] s_a, input logic x_w);
        @(negedge clk);
        arm_v = a_v; arm_a = a_a; go = g; rsp_v = r_v; rsp_a = r_a;
        snp_v = s_v; snp_a = s_a; ext_w = x_w;
        @(posedge clk);
        model_step();
        #2;
        chk("halt_o", 64'(halt), 64'(m_wait));
        chk("wake_o", 64'(wake), 64'(e_wake));
        chk("wait_done_o", 64'(done), 64'(e_done));
        chk("rd_req_o", 64'(rd_req), 64'(e_rd_req));
        if (e_rd_req) begin
            chk("rd_addr_o", rd_addr, e_rd_addr);
            chk("rd_size_o", 64'(rd_size), 64'(e_rd_size));
        end
    endtask

    task automatic idle();
        step(0, '0, 0, 0, '0, 0, '0, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7741);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        cur_tag = "R1";
        chk("halt_o", 64'(halt), 0);
        chk("wake_o", 64'(wake), 0);
        chk("rd_req_o", 64'(rd_req), 0);
        chk("wait_done_o", 64'(done), 0);

        // R2 and R3: arm near the line end, read is cut to 4 bytes
        cur_tag = "R2 R3";
        step(1, 64'h0000_7000_0001_003C, 0, 0, '0, 0, '0, 0);
        step(0, '0, 1, 0, '0, 0, '0, 0);
        idle();
        // R5: response captures line 0x5000_0040 and halts
        cur_tag = "R5";
        step(0, '0, 0, 1, 64'h0000_0000_5000_0077, 0, '0, 0);
        idle();
        // R8: snoop of a neighbouring line changes nothing
        cur_tag = "R8";
        step(0, '0, 0, 0, '0, 1, 64'h0000_0000_5000_0080, 0);
        // R7 and R9: snoop inside the line wakes and leaves a pending wake
        cur_tag = "R7 R9";
        step(0, '0, 0, 0, '0, 1, 64'h0000_0000_5000_0051, 0);
        idle();
        // R6: the next wait consumes the pending wake without halting
        cur_tag = "R6";
        step(0, '0, 1, 0, '0, 0, '0, 0);
        step(0, '0, 0, 1, 64'h0000_0000_5000_0040, 0, '0, 0);
        // R8: snoop while not waiting does nothing
        cur_tag = "R8";
        step(0, '0, 0, 0, '0, 1, 64'h0000_0000_5000_0040, 0);
        // R4: stray response, then a second go while the read is outstanding
        cur_tag = "R4";
        step(0, '0, 0, 1, 64'h0000_0000_5000_0040, 0, '0, 0);
        step(0, '0, 1, 0, '0, 0, '0, 0);
        step(0, '0, 1, 0, '0, 0, '0, 0);
        step(0, '0, 0, 1, 64'h0000_0000_6000_0100, 0, '0, 0);
        // R10: re-arm while waiting, then the old line no longer wakes
        cur_tag = "R10";
        step(1, 64'h0000_7000_0002_0000, 0, 0, '0, 0, '0, 0);
        step(0, '0, 0, 0, '0, 1, 64'h0000_0000_6000_0100, 0);
        // R11: response and matching snoop in the same cycle
        cur_tag = "R11";
        step(0, '0, 1, 0, '0, 0, '0, 0);
        step(0, '0, 0, 1, 64'h0000_0000_6000_0200, 1, 64'h0000_0000_6000_023F, 0);
        idle();
        // R6 again: pending wake from R11 is consumed
        cur_tag = "R6";
        step(0, '0, 1, 0, '0, 0, '0, 0);
        step(0, '0, 0, 1, 64'h0000_0000_6000_0200, 0, '0, 0);
        // R12: arm and response together, then a late response and arm with go
        cur_tag = "R12";
        step(0, '0, 1, 0, '0, 0, '0, 0);
        step(1, 64'h0000_7000_0003_003E, 0, 1, 64'h0000_0000_6000_0300, 0, '0, 0);
        step(0, '0, 0, 1, 64'h0000_0000_6000_0300, 0, '0, 0);
        step(1, 64'h0000_7000_0004_0039, 1, 0, '0, 0, '0, 0);
        // R9: external wake makes the next wait return at once
        cur_tag = "R9";
        step(0, '0, 0, 0, '0, 0, '0, 1);
        step(0, '0, 0, 1, 64'h0000_0000_6000_0400, 0, '0, 0);
        idle();

        // random traffic
        cur_tag = "R3 R5 R7 R8 R9 random";
        for (int i = 0; i < 4000; i++) begin
            logic a_v, g, r_v, s_v, x_w;
            logic [63:0] a_a, r_a, s_a;
            a_v = ($urandom % 100) < 3;
            a_a = 64'h0000_7000_0000_0000 + 64'($urandom % 4096);
            g   = ($urandom % 100) < 20;
            r_v = ($urandom % 100) < (m_busy ? 40 : 5);
            r_a = 64'h0000_0000_8000_0000 + 64'(($urandom % 8) * LINE) + 64'($urandom % LINE);
            s_v = ($urandom % 100) < 40;
            if (($urandom % 100) < 60)
                s_a = m_line + 64'($urandom % LINE);
            else
                s_a = 64'h0000_0000_8000_0000 + 64'(($urandom % 8) * LINE) + 64'($urandom % LINE);
            x_w = ($urandom % 100) < 3;
            step(a_v, a_a, g, r_v, r_a, s_v, s_a, x_w);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule